// File: doc/BRIEF.md
# No-Load Gated Energy Pulse Generator

The block converts a stream of signed fractional energy increments, one per output-word-rate sample, into output pulses. Each increment is added to a pulse accumulator. Whenever the accumulator reaches one full unit, a pulse is produced and one unit is taken back out of the accumulator. Every pulse is stretched to a programmed number of sample periods. A width setting of zero selects a fixed fallback width that is set at build time.

A second accumulator adds up the same increments over a programmable window of samples. At the end of each window the total is compared with a minimum energy value. If the total falls short, pulse output is suppressed for the following window. If the window length or the minimum is zero, detection is off and pulses always pass.

The three settings are loaded through a small parallel write port. A write takes effect on the next clock.

Top module: `nlpulse_gen`

## Requirements
- R1: After reset the pulse output is low, all three settings are zero, and pulses are enabled.
- R2: On each sample strobe the signed Q1.23 increment is added to the pulse accumulator. When the sum is at least +1.0 (0x800000 in units of 2^-23), a pulse is requested and 1.0 is subtracted.
- R3: A granted pulse drives the output high in the cycle after the firing strobe. The output stays high for W strobes and falls in the cycle after the W-th following strobe, where W is the width setting (address 0, low 20 bits).
- R4: A width setting of 0 uses the fallback width LEGACY_SAMPLES (default 3 strobes).
- R5: A pulse request that arrives while a pulse is high is dropped, but its 1.0 is still subtracted from the accumulator.
- R6: When the window length (address 1) or the minimum energy (address 2) is zero, no-load detection is off and every pulse request is granted.
- R7: With detection on, the strobe that completes the window-length count compares the window sum with the minimum. It enables pulses if the sum is at least the minimum and disables them otherwise. The decision applies from the next cycle, and the window sum and count then clear.
- R8: While pulses are disabled, accumulator crossings still subtract 1.0 but produce no pulse.
- R9: A pulse already high runs its full width even if pulses become disabled during it.
- R10: A write of a negative value (bit 23 set) to the minimum energy setting stores 0.
- R11: The pulse accumulator saturates at -1.0 and never goes lower.
- R12: A write to the window length or the minimum energy restarts the current window: its sum and count clear without changing the enable decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | One-cycle strobe per sample |
| smp_energy | input | 24 | Signed Q1.23 energy increment |
| wr_en | input | 1 | Setting write strobe |
| wr_addr | input | 2 | Setting select: 0 width, 1 window length, 2 minimum energy |
| wr_data | input | 24 | Setting write data |
| pulse_out | output | 1 | Stretched energy pulse |

## Verification
Every result registers once, so a strobe's effect on the pulse output can be seen one cycle after the clock edge that samples it. The bench drives each strobe or write for a single edge and compares the output at the following falling edge. There the output is checked against a bench model advanced by that same edge. The gate decision and any new setting act only from the next edge. The model applies the window update with the settings held before the write, and then applies the write, which matches that one-cycle lag.

// File: rtl/nlp_pkg.sv
package nlp_pkg;
    typedef enum logic [1:0] {
        SEL_WIDTH  = 2'd0,
        SEL_WINLEN = 2'd1,
        SEL_MINE   = 2'd2,
        SEL_NONE   = 2'd3
    } set_sel_e;
endpackage

// File: rtl/nlp_acc.sv
module nlp_acc #(
    parameter int FRAC_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid,
    input  logic signed [FRAC_W-1:0] energy,
    output logic                     fire,
    output logic signed [FRAC_W+1:0] acc_val
);
    localparam int AW = FRAC_W + 2;
    localparam logic signed [AW-1:0] ONE = {2'b00, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic signed [AW-1:0] NEG_ONE = -ONE;

    typedef struct packed {
        logic signed [AW-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic signed [AW-1:0] e_x, sum;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        e_x  = AW'(energy);
        sum  = st_q.acc + e_x;
        if (valid) begin
            if (sum >= ONE) begin
                fire       = 1'b1;
                st_d.acc   = sum - ONE;
            end else if (sum < NEG_ONE) begin
                st_d.acc   = NEG_ONE;
            end else begin
                st_d.acc   = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_val = st_q.acc;
endmodule

// File: rtl/nlp_stretch.sv
module nlp_stretch #(
    parameter int WIDTH_W        = 20,
    parameter int LEGACY_SAMPLES = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic               start_req,
    input  logic [WIDTH_W-1:0] width,
    output logic               pulse
);
    localparam logic [WIDTH_W-1:0] LEG_W = WIDTH_W'(LEGACY_SAMPLES);

    typedef struct packed {
        logic               active;
        logic [WIDTH_W-1:0] cnt;
    } str_st_t;

    str_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid) begin
            if (st_q.active) begin
                if (st_q.cnt == WIDTH_W'(1)) st_d.active = 1'b0;
                st_d.cnt = st_q.cnt - WIDTH_W'(1);
            end else if (start_req) begin
                st_d.active = 1'b1;
                st_d.cnt    = (width == '0) ? LEG_W : width;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.active;
endmodule

// File: rtl/nlp_window.sv
module nlp_window #(
    parameter int FRAC_W = 24,
    parameter int WIN_W  = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid,
    input  logic signed [FRAC_W-1:0] energy,
    input  logic [WIN_W-1:0]         win_len,
    input  logic signed [FRAC_W-1:0] min_e,
    input  logic                     restart,
    output logic                     enable
);
    localparam int SW = FRAC_W + WIN_W;

    typedef struct packed {
        logic                 en;
        logic [WIN_W-1:0]     cnt;
        logic signed [SW-1:0] sum;
    } win_st_t;

    win_st_t st_d, st_q;
    logic                 detect;
    logic [WIN_W-1:0]     cnt_inc;
    logic signed [SW-1:0] sum_inc, min_x;

    always_comb begin
        st_d    = st_q;
        detect  = (win_len != '0) && (min_e != '0);
        cnt_inc = st_q.cnt + WIN_W'(1);
        sum_inc = st_q.sum + SW'(energy);
        min_x   = SW'(min_e);
        if (!detect) begin
            st_d.en  = 1'b1;
            st_d.cnt = '0;
            st_d.sum = '0;
        end else if (restart) begin
            st_d.cnt = '0;
            st_d.sum = '0;
        end else if (valid) begin
            if (cnt_inc == win_len) begin
                st_d.en  = (sum_inc >= min_x);
                st_d.cnt = '0;
                st_d.sum = '0;
            end else begin
                st_d.cnt = cnt_inc;
                st_d.sum = sum_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{en: 1'b1, cnt: '0, sum: '0};
        else        st_q <= st_d;
    end

    assign enable = st_q.en;
endmodule

// File: rtl/nlpulse_gen.sv
module nlpulse_gen
    import nlp_pkg::*;
#(
    parameter int FRAC_W         = 24,
    parameter int WIN_W          = 24,
    parameter int WIDTH_W        = 20,
    parameter int LEGACY_SAMPLES = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [FRAC_W-1:0] smp_energy,
    input  logic                     wr_en,
    input  logic [1:0]               wr_addr,
    input  logic [WIN_W-1:0]         wr_data,
    output logic                     pulse_out
);
    typedef struct packed {
        logic [WIDTH_W-1:0]     width;
        logic [WIN_W-1:0]       winlen;
        logic signed [FRAC_W-1:0] mine;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;
    set_sel_e sel;
    logic fire, gate_en, start_req, restart;
    logic signed [FRAC_W+1:0] acc_val;
    logic [WIN_W-1:0] winlen_q;
    logic signed [FRAC_W-1:0] mine_q;

    always_comb begin
        cfg_d = cfg_q;
        sel   = set_sel_e'(wr_addr);
        if (wr_en) begin
            case (sel)
                SEL_WIDTH:  cfg_d.width  = wr_data[WIDTH_W-1:0];
                SEL_WINLEN: cfg_d.winlen = wr_data;
                SEL_MINE:   cfg_d.mine   = wr_data[FRAC_W-1] ? '0 : wr_data[FRAC_W-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign restart   = wr_en && ((sel == SEL_WINLEN) || (sel == SEL_MINE));
    assign start_req = fire && gate_en;
    assign winlen_q  = cfg_q.winlen;
    assign mine_q    = cfg_q.mine;

    nlp_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .valid(smp_valid), .energy(smp_energy),
        .fire(fire), .acc_val(acc_val)
    );

    nlp_window #(.FRAC_W(FRAC_W), .WIN_W(WIN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .valid(smp_valid), .energy(smp_energy),
        .win_len(winlen_q), .min_e(mine_q), .restart(restart), .enable(gate_en)
    );

    nlp_stretch #(.WIDTH_W(WIDTH_W), .LEGACY_SAMPLES(LEGACY_SAMPLES)) u_str (
        .clk(clk), .rst_n(rst_n), .valid(smp_valid), .start_req(start_req),
        .width(cfg_q.width), .pulse(pulse_out)
    );
endmodule

// File: rtl/nlp_chk.sv
module nlp_chk #(
    parameter int FRAC_W = 24,
    parameter int WIN_W  = 24
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     smp_valid,
    input logic                     pulse_out,
    input logic                     gate_en,
    input logic signed [FRAC_W+1:0] acc_val,
    input logic [WIN_W-1:0]         winlen_q,
    input logic signed [FRAC_W-1:0] mine_q
);
    localparam logic signed [FRAC_W+1:0] ONE = {2'b00, 1'b1, {(FRAC_W-1){1'b0}}};
    logic det_off;
    assign det_off = (winlen_q == '0) || (mine_q == '0);

    AST_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(smp_valid)); // R3
    AST_FALL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_out) |-> $past(smp_valid)); // R3
    AST_RISE_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(gate_en)); // R8
    AST_DETECT_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        det_off |=> gate_en); // R6
    AST_GATE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gate_en) |-> ($past(smp_valid) || $past(det_off))); // R7
    AST_MIN_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        !mine_q[FRAC_W-1]); // R10
    AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_val < ONE) && (acc_val >= -ONE)); // R11
endmodule

bind nlpulse_gen nlp_chk #(.FRAC_W(FRAC_W), .WIN_W(WIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .pulse_out(pulse_out),
    .gate_en(gate_en), .acc_val(acc_val), .winlen_q(winlen_q), .mine_q(mine_q)
);

// File: tb/nlpulse_gen_test.sv
module nlpulse_gen_test;
    localparam longint ONE = 64'sd1 << 23;
    localparam int     LEG = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_energy = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        pulse_out;

    int tests = 0;
    int fails = 0;

    longint m_acc = 0, m_ws = 0, m_min = 0;
    int     m_cnt = 0, m_wc = 0, m_w = 0, m_len = 0;
    bit     m_active = 0, m_en = 1;

    nlpulse_gen uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_energy(smp_energy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pulse_out(pulse_out)
    );

    always #2 clk = ~clk;

    task automatic check(input logic act, input logic exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: pulse_out=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit v, input logic [23:0] e, input bit w,
                              input logic [1:0] a, input logic [23:0] d);
        longint ev = longint'($signed(e));
        longint sum = m_acc + ev;
        bit det = (m_len != 0) && (m_min != 0);
        bit fire_raw = 0;
        bit old_active = m_active;
        bit old_en = m_en;
        if (v) begin
            if (sum >= ONE) begin fire_raw = 1; m_acc = sum - ONE; end
            else if (sum < -ONE) m_acc = -ONE;
            else m_acc = sum;
            if (old_active) begin
                m_cnt--;
                if (m_cnt == 0) m_active = 0;
            end else if (fire_raw && old_en) begin
                m_active = 1;
                m_cnt = (m_w == 0) ? LEG : m_w;
            end
        end
        if (!det) begin m_en = 1; m_wc = 0; m_ws = 0; end
        else if (w && (a == 2'd1 || a == 2'd2)) begin m_wc = 0; m_ws = 0; end
        else if (v) begin
            m_ws += ev; m_wc++;
            if (m_wc == m_len) begin m_en = (m_ws >= m_min); m_wc = 0; m_ws = 0; end
        end
        if (w) begin
            case (a)
                2'd0: m_w = int'(d[19:0]);
                2'd1: m_len = int'(d);
                2'd2: m_min = d[23] ? 0 : longint'(d);
                default: ;
            endcase
        end
    endtask

    task automatic cyc(input bit v, input logic [23:0] e, input bit w,
                       input logic [1:0] a, input logic [23:0] d, input string tag);
        smp_valid = v; smp_energy = e; wr_en = w; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_step(v, e, w, a, d);
        @(negedge clk);
        smp_valid = 1'b0; wr_en = 1'b0;
        check(pulse_out, m_active, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d, input string tag);
        cyc(0, '0, 1, a, d, tag);
        cyc(0, '0, 0, 0, 0, tag);
    endtask

    task automatic strobes(input int n, input logic [23:0] e, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1, e, 0, 0, 0, tag);
            cyc(0, '0, 0, 0, 0, tag);
        end
    endtask

    function automatic logic [23:0] pat(input int k, input int sel);
        case ((k + sel) % 4)
            0: return 24'h7FFFFF;
            1: return 24'h020000;
            2: return 24'hF00000;
            default: return 24'h300000;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [23:0] elist [5] = '{24'h200000, 24'h400000, 24'h7FFFFF, 24'h155555, 24'h0C0000};
        logic [23:0] mlist [3] = '{24'h080000, 24'h300000, 24'h700000};
        repeat (3) @(negedge clk);
        check(pulse_out, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(pulse_out, 1'b0, "R1 after reset");
        strobes(6, 24'h7FFFFF, "R1 enabled after reset");

        wr(2'd0, 24'd1, "R2");
        foreach (elist[i]) strobes(16, elist[i], "R2");

        for (int w = 0; w <= 5; w++) begin
            wr(2'd0, 24'(w), (w == 0) ? "R4" : "R3");
            strobes(20, 24'h7FFFFF, (w == 0) ? "R4" : "R3");
            strobes(20, 24'h600000, "R5");
        end

        wr(2'd0, 24'd1, "R11");
        strobes(5, 24'h800000, "R11");
        strobes(8, 24'h400000, "R11");

        wr(2'd0, 24'd2, "R7");
        for (int len = 1; len <= 4; len++) begin
            foreach (mlist[j]) begin
                wr(2'd1, 24'(len), "R7");
                wr(2'd2, mlist[j], "R7");
                for (int k = 0; k < 24; k++) begin
                    cyc(1, pat(k, len + j), 0, 0, 0, "R7 R8");
                    cyc(0, '0, 0, 0, 0, "R7 R8");
                end
            end
        end

        wr(2'd0, 24'd6, "R9");
        wr(2'd1, 24'd3, "R9");
        wr(2'd2, 24'h500000, "R9");
        for (int k = 0; k < 40; k++) begin
            cyc(1, pat(k, 1), 0, 0, 0, "R9");
            cyc(0, '0, 0, 0, 0, "R9");
        end

        wr(2'd0, 24'd1, "R12");
        for (int r = 0; r < 6; r++) begin
            strobes(2, 24'h7FFFFF, "R12");
            wr(2'd1, 24'd3, "R12");
            strobes(1, 24'h010000, "R12");
        end

        wr(2'd1, 24'd0, "R6");
        wr(2'd2, 24'h7FFFFF, "R6");
        strobes(20, 24'h100000, "R6");
        wr(2'd1, 24'd4, "R6");
        wr(2'd2, 24'd0, "R6");
        strobes(20, 24'h100000, "R6");

        wr(2'd1, 24'd2, "R10");
        wr(2'd2, 24'hC00000, "R10");
        strobes(30, 24'h100000, "R10");
        wr(2'd2, 24'h7FFFFF, "R10");
        strobes(30, 24'h100000, "R10");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule